// File: doc/BRIEF.md
# Dual-Polarity Response Frame Receiver

This block takes in a response telegram that a chain node sends back over two wires, a bit clock and a data line. The node gives no chip select. A sequencer opens a receive window with `winEn` after it has sent a command. The block treats a rising edge of the bit clock as a valid data edge only inside that window. It shifts the bits in most significant bit first and stores each complete byte in a twelve-byte buffer. The sequencer reads the buffer through a simple address port.

A node at the near end of the chain sends with its clock resting low. A node at the far end sends with its clock resting high. The block captures on rising edges only, in both cases. The sequencer tells it which resting level to expect through `idleHigh`. In the resting-high case, a rising edge is not trusted until the clock has first gone low inside the window. A frame ends in one of two ways: the window closes, or the clock stays quiet for a programmable number of system cycles after at least one edge. That quiet time is about two bit times at the nominal bit rate.

The block drives several results while a frame is received and after it ends:
- a live count of accepted clock edges, which the sequencer uses to time the window;
- the number of complete bytes;
- a done flag;
- a valid flag, a partial-byte flag and an overflow flag.

Top module: `resp_frame_rx`

## Requirements
- R1: Data is sampled on each accepted rising edge of `rxClk`, most significant bit first. Byte k of the frame (k counted from 0) is read at `rdAddr` = k once that byte is complete.
- R2: With `idleHigh`=0, every rising edge inside the window is accepted. With `idleHigh`=1, rising edges are ignored until `rxClk` has been seen low-going at least once inside the window.
- R3: A frame ends when `winEn` goes low. It also ends when `rxClk` shows no rising edge for `IDLE_CYCLES` system clocks after at least one accepted edge. After the end, `rxClk` and `rxData` have no effect on `edgeCount`, `byteCount` or the flags until a new window opens.
- R4: `edgeCount` is live. It rises by exactly one for each accepted edge, within three system clocks of that edge.
- R5: `byteCount` counts complete bytes only. It always equals `edgeCount` divided by 8, rounded down.
- R6: If the window closes before a full byte has arrived, `byteCount` reads 0 and `frameValid` is 0.
- R7: Edges beyond 96 are dropped. `edgeCount` stays at 96, the buffer keeps its contents, and `overflow` is set until the next window.
- R8: At frame end, `partialErr` is 1 exactly when the number of kept edges is not a multiple of 8.
- R9: At frame end, `frameValid` is 1 exactly when at least one byte was kept, no partial byte is left and no overflow occurred.
- R10: After reset, `edgeCount`, `byteCount`, `frameValid`, `partialErr`, `overflow` and `frameDone` are all 0.
- R11: Opening a window (`winEn` going from 0 to 1 while idle) clears the counts and all flags. `frameDone` goes to 1 at frame end and holds until the next window opens.
- R12: `rdData` is 0 for any `rdAddr` of 12 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| winEn | input | 1 | Receive window from the sequencer |
| idleHigh | input | 1 | 1 when the sender's clock rests high |
| rxClk | input | 1 | Bit clock from the node (asynchronous) |
| rxData | input | 1 | Data from the node (asynchronous) |
| rdAddr | input | 4 | Buffer read address |
| rdData | output | 8 | Buffer byte at `rdAddr` |
| edgeCount | output | 7 | Live count of kept clock edges |
| byteCount | output | 4 | Complete bytes stored |
| frameDone | output | 1 | Frame has ended |
| frameValid | output | 1 | Frame ended clean, with one or more bytes |
| partialErr | output | 1 | Frame ended with a partial byte |
| overflow | output | 1 | More than 96 edges arrived |

## Verification
The bench targets these cases, and the symptom a wrong design would show in each:
- **Stray rise in the resting-high case.** The clock sits low when the window opens and then rises to its resting level. A design that accepts that rise shifts every byte by one bit and counts one edge too many.
- **Quiet-time end.** After the clock goes quiet, more edges are sent with the window still open. A design with a broken timeout keeps counting them.
- **Clearing on a new window.** A frame with 100 edges must stop at 96. The next window must then start from zero flags; a design that fails to clear would carry the overflow forward.
- **Early window close.** A window that closes mid-byte must report zero bytes with the partial-byte flag set.
- **Random traffic.** Random frames in both clock polarities check the exact byte order and the live edge count.

// File: rtl/frx_pkg.sv
package frx_pkg;

  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic clear;   // new window: wipe counts and flags
    logic accept;  // take the current rising edge as a data edge
    logic finish;  // frame ends now: latch result flags
  } frxCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DONE = 2'd2
  } frxState_t;

endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/frx_datapath.sv
module frx_datapath
  import frx_pkg::*;
#(
  parameter int MAX_BYTES   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              rxClk,
  input  logic                              rxData,
  input  frxCtl_t                           ctl,
  input  logic [$clog2(MAX_BYTES)-1:0]      rdAddr,
  output logic [7:0]                        rdData,
  output logic                              rise,
  output logic                              fall,
  output logic [$clog2(MAX_BYTES*8+1)-1:0]  edgeCnt,
  output logic [$clog2(MAX_BYTES+1)-1:0]    byteCnt,
  output logic                              frameValid,
  output logic                              partialErr,
  output logic                              overflow
);

  localparam int MAX_EDGES = MAX_BYTES * 8;
  localparam int EDGE_W    = $clog2(MAX_EDGES + 1);
  localparam int BYTE_W    = $clog2(MAX_BYTES + 1);
  localparam int ADDR_W    = $clog2(MAX_BYTES);

  logic [1:0] syncBus;
  logic       clkS;
  logic       dataS;
  logic       clkPrev;
  logic [2:0] bitIdx;
  logic [6:0] shReg;
  logic [7:0] nextByte;
  logic       room;
  logic       takeBit;
  logic       commit;
  logic [7:0] store [MAX_BYTES];

  // The clock and the data go through the same stages, so they stay aligned.
  frx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({rxClk, rxData}),
    .syncOut(syncBus)
  );

  assign clkS  = syncBus[1];
  assign dataS = syncBus[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkS;
  end

  assign rise     = clkS & ~clkPrev;
  assign fall     = ~clkS & clkPrev;
  assign room     = (edgeCnt != EDGE_W'(MAX_EDGES));
  assign takeBit  = ctl.accept & room;
  assign commit   = takeBit & (bitIdx == 3'd7);
  assign nextByte = {shReg, dataS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt    <= '0;
      byteCnt    <= '0;
      bitIdx     <= '0;
      shReg      <= '0;
      overflow   <= 1'b0;
      partialErr <= 1'b0;
      frameValid <= 1'b0;
    end else if (ctl.clear) begin
      edgeCnt    <= '0;
      byteCnt    <= '0;
      bitIdx     <= '0;
      shReg      <= '0;
      overflow   <= 1'b0;
      partialErr <= 1'b0;
      frameValid <= 1'b0;
    end else begin
      if (ctl.accept && !room) overflow <= 1'b1;
      if (takeBit) begin
        edgeCnt <= edgeCnt + 1'b1;
        bitIdx  <= bitIdx + 1'b1;
        shReg   <= nextByte[6:0];
      end
      if (commit) byteCnt <= byteCnt + 1'b1;
      if (ctl.finish) begin
        partialErr <= (bitIdx != 3'd0);
        frameValid <= (byteCnt != '0) && (bitIdx == 3'd0) && !overflow;
      end
    end
  end

  generate
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          store[b] <= '0;
        else if (commit && byteCnt == BYTE_W'(b))
          store[b] <= nextByte;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int i = 0; i < MAX_BYTES; i++)
      if (rdAddr == ADDR_W'(i)) rdData = store[i];
  end

  p_edge_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EDGE_W'(MAX_EDGES));

  p_edge_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt != $past(edgeCnt)) |-> (edgeCnt == $past(edgeCnt) + 1'b1) || (edgeCnt == '0));

  p_overflow_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ctl.clear) |=> overflow);

  p_bytes_track_r5: assert property (@(posedge clk) disable iff (!rstN)
    32'(byteCnt) == 32'(edgeCnt) / 8);

  p_valid_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> !partialErr && !overflow && byteCnt != '0);

endmodule

// File: rtl/frx_ctrl.sv
module frx_ctrl
  import frx_pkg::*;
#(
  parameter int IDLE_CYCLES = 104
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    winEn,
  input  logic    idleHigh,
  input  logic    rise,
  input  logic    fall,
  output frxCtl_t ctl,
  output logic    frameDone
);

  localparam int Q_W = $clog2(IDLE_CYCLES + 1);

  frxState_t      state;
  logic [Q_W-1:0] quietCnt;
  logic           gotEdge;
  logic           armed;
  logic           timeout;

  assign timeout = gotEdge && (quietCnt == Q_W'(IDLE_CYCLES));

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: ctl.clear = winEn;
      ST_RECV: begin
        if (!winEn || timeout)  ctl.finish = 1'b1;
        else if (rise && armed) ctl.accept = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      quietCnt  <= '0;
      gotEdge   <= 1'b0;
      armed     <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (winEn) begin
            state     <= ST_RECV;
            armed     <= ~idleHigh;
            gotEdge   <= 1'b0;
            quietCnt  <= '0;
            frameDone <= 1'b0;
          end
        end
        ST_RECV: begin
          if (ctl.finish) begin
            state     <= ST_DONE;
            frameDone <= 1'b1;
          end else if (ctl.accept) begin
            gotEdge  <= 1'b1;
            quietCnt <= '0;
          end else if (gotEdge && quietCnt != Q_W'(IDLE_CYCLES)) begin
            quietCnt <= quietCnt + 1'b1;
          end
          if (fall) armed <= 1'b1;
        end
        default: begin
          if (!winEn) state <= ST_IDLE;
        end
      endcase
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.clear, ctl.accept, ctl.finish}));

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !ctl.clear) |=> frameDone);

  p_first_rise_blocked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && winEn && idleHigh) |=> !ctl.accept);

endmodule

// File: rtl/resp_frame_rx.sv
module resp_frame_rx
  import frx_pkg::*;
#(
  parameter int MAX_BYTES   = 12,
  parameter int IDLE_CYCLES = 104,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              winEn,
  input  logic                              idleHigh,
  input  logic                              rxClk,
  input  logic                              rxData,
  input  logic [$clog2(MAX_BYTES)-1:0]      rdAddr,
  output logic [7:0]                        rdData,
  output logic [$clog2(MAX_BYTES*8+1)-1:0]  edgeCount,
  output logic [$clog2(MAX_BYTES+1)-1:0]    byteCount,
  output logic                              frameDone,
  output logic                              frameValid,
  output logic                              partialErr,
  output logic                              overflow
);

  frxCtl_t ctl;
  logic    rise;
  logic    fall;

  frx_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .winEn    (winEn),
    .idleHigh (idleHigh),
    .rise     (rise),
    .fall     (fall),
    .ctl      (ctl),
    .frameDone(frameDone)
  );

  frx_datapath #(.MAX_BYTES(MAX_BYTES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxClk     (rxClk),
    .rxData    (rxData),
    .ctl       (ctl),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .rise      (rise),
    .fall      (fall),
    .edgeCnt   (edgeCount),
    .byteCnt   (byteCount),
    .frameValid(frameValid),
    .partialErr(partialErr),
    .overflow  (overflow)
  );

  p_frozen_after_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && $past(frameDone)) |-> $stable(edgeCount) && $stable(byteCount) && $stable(overflow));

endmodule

// File: tb/resp_frame_rx_bench.sv
module resp_frame_rx_bench;

  localparam int MAX_BYTES   = 12;
  localparam int MAX_EDGES   = MAX_BYTES * 8;
  localparam int IDLE_CYCLES = 104;
  localparam int HP          = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       winEn = 1'b0;
  logic       idleHigh = 1'b0;
  logic       rxClk = 1'b0;
  logic       rxData = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [6:0] edgeCount;
  logic [3:0] byteCount;
  logic       frameDone, frameValid, partialErr, overflow;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;
  logic [7:0] stim [16];

  always #4 clk = ~clk;

  resp_frame_rx #(.MAX_BYTES(MAX_BYTES), .IDLE_CYCLES(IDLE_CYCLES)) u_resp_frame_rx (
    .clk(clk), .rstN(rstN), .winEn(winEn), .idleHigh(idleHigh),
    .rxClk(rxClk), .rxData(rxData), .rdAddr(rdAddr), .rdData(rdData),
    .edgeCount(edgeCount), .byteCount(byteCount), .frameDone(frameDone),
    .frameValid(frameValid), .partialErr(partialErr), .overflow(overflow)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int kept(int nbits);
    return (nbits > MAX_EDGES) ? MAX_EDGES : nbits;
  endfunction

  // Bits counted from frame start, taken from stim MSB first.
  task automatic sendBits(int first, int nbits, bit mode3);
    for (int i = first; i < first + nbits; i++) begin
      if (mode3) begin
        rxClk = 1'b0; rxData = stim[i/8][7-(i%8)];
        waitNeg(HP); rxClk = 1'b1; waitNeg(HP);
      end else begin
        rxData = stim[i/8][7-(i%8)];
        waitNeg(HP); rxClk = 1'b1; waitNeg(HP); rxClk = 1'b0;
      end
    end
  endtask

  task automatic openWin(bit mode3);
    idleHigh = mode3; rxClk = mode3;
    waitNeg(6); winEn = 1'b1; waitNeg(4);
  endtask

  task automatic checkResult(string tag, int nbits);
    int k = kept(nbits);
    int nb = k / 8;
    check("R3", {tag, " done"}, frameDone, 1);
    check("R4", {tag, " edges"}, edgeCount, k);
    check("R5", {tag, " bytes"}, byteCount, nb);
    check("R7", {tag, " overflow"}, overflow, nbits > MAX_EDGES);
    check("R8", {tag, " partial"}, partialErr, (k % 8) != 0);
    check("R9", {tag, " valid"}, frameValid, (nb > 0) && (k % 8 == 0) && (nbits <= MAX_EDGES));
    for (int b = 0; b < nb; b++) begin
      rdAddr = 4'(b); #1;
      check("R1", {tag, " byte"}, rdData, stim[b]);
    end
  endtask

  task automatic fullFrame(string tag, int nbits, bit mode3);
    openWin(mode3);
    sendBits(0, nbits, mode3);
    waitNeg(IDLE_CYCLES + 20);
    checkResult(tag, nbits);
    winEn = 1'b0; waitNeg(4);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    waitNeg(3);
    // R10: reset state
    check("R10", "edges", edgeCount, 0);
    check("R10", "bytes", byteCount, 0);
    check("R10", "flags", {frameDone, frameValid, partialErr, overflow}, 0);
    rstN = 1'b1; waitNeg(3);

    // R1/R2 idle-low, 3 bytes
    stim[0] = 8'hA0; stim[1] = 8'h09; stim[2] = 8'h6D;
    fullFrame("mode0", 24, 1'b0);

    // R2: resting-high sender, clock low at window open then stray rise
    stim[0] = 8'hC3; stim[1] = 8'h5A;
    idleHigh = 1'b1; rxClk = 1'b0; waitNeg(6);
    winEn = 1'b1; waitNeg(4);
    rxClk = 1'b1; waitNeg(HP);
    sendBits(0, 16, 1'b1);
    waitNeg(IDLE_CYCLES + 20);
    checkResult("R2 stray", 16);
    winEn = 1'b0; waitNeg(4);

    // R4 live count, then R3 freeze after quiet-time end
    stim[0] = 8'h11; stim[1] = 8'h22; stim[2] = 8'h33; stim[3] = 8'h44;
    openWin(1'b0);
    sendBits(0, 20, 1'b0);
    waitNeg(4);
    check("R4", "live edges", edgeCount, 20);
    check("R4", "not done yet", frameDone, 0);
    sendBits(20, 4, 1'b0);
    waitNeg(IDLE_CYCLES + 20);
    checkResult("live", 24);
    sendBits(24, 8, 1'b0);
    waitNeg(4);
    check("R3", "edges frozen", edgeCount, 24);
    check("R3", "bytes frozen", byteCount, 3);
    check("R3", "valid kept", frameValid, 1);
    winEn = 1'b0; waitNeg(4);
    sendBits(0, 8, 1'b0);
    waitNeg(4);
    check("R3", "closed window edges", edgeCount, 24);

    // R6: empty window and early close mid-byte
    openWin(1'b0);
    winEn = 1'b0; waitNeg(4);
    check("R6", "empty bytes", byteCount, 0);
    check("R6", "empty valid", frameValid, 0);
    check("R11", "empty done", frameDone, 1);
    openWin(1'b1);
    sendBits(0, 5, 1'b1);
    winEn = 1'b0; waitNeg(4);
    check("R6", "early bytes", byteCount, 0);
    check("R6", "early valid", frameValid, 0);
    check("R8", "early partial", partialErr, 1);
    check("R4", "early edges", edgeCount, 5);

    // R7: 100 edges
    for (int b = 0; b < 16; b++) stim[b] = 8'($urandom);
    fullFrame("R7 over", 100, 1'b0);

    // R11: new window clears flags
    openWin(1'b0);
    check("R11", "clear overflow", overflow, 0);
    check("R11", "clear edges", edgeCount, 0);
    check("R11", "clear done", frameDone, 0);
    winEn = 1'b0; waitNeg(4);

    // R12: out-of-range read
    rdAddr = 4'd12; #1; check("R12", "addr12", rdData, 0);
    rdAddr = 4'd15; #1; check("R12", "addr15", rdData, 0);

    // random frames in both polarities
    for (int f = 0; f < 12; f++) begin
      int nbytes = 1 + int'($urandom % 12);
      int extra  = (($urandom % 4) == 0) ? 1 + int'($urandom % 7) : 0;
      bit m3     = 1'($urandom);
      for (int b = 0; b < 16; b++) stim[b] = 8'($urandom);
      fullFrame("rand", nbytes * 8 + extra, m3);
    end

    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule